// File: doc/BRIEF.md
# Priority-Muxed General-Purpose I/O Port

This block is an eight-pin general-purpose port in which peripheral units can take over pins. The pins fall into two groups of four, called nibbles, and each nibble picks its owner on its own. A stall-detect unit takes precedence over a pair of motor PWM channels. The PWM pair in turn takes precedence over plain GPIO. The upper nibble (pins 7..4) listens to the upper stall-detect unit and to PWM channels 3 and 2. The lower nibble (pins 3..0) listens to the lower stall-detect unit and to PWM channels 1 and 0.

Software reaches three registers over a small register bus: a data latch, a direction register and a per-pin slew-control register. Reading the data register gives one of three values for each bit, depending on that bit's direction and slew settings: the latch, a forced one, or the synchronized pin level. The synchronized pin levels also go out to the peripherals.

Top module: `pv_port_mux`

## Requirements
- R1: Each nibble picks exactly one owner, and the two nibbles decide independently. A stall-detect enable beats a PWM enable. When neither enable is set, GPIO owns the nibble.
- R2: When stall-detect owns a nibble, that nibble's `pad_out` and `pad_oe` bits copy the unit's `stall_out` and `stall_oe` bits at the same positions, combinationally.
- R3: When a PWM pair owns nibble n, its pins from high to low carry pwm_p[2n+1], pwm_m[2n+1], pwm_p[2n], pwm_m[2n], and all four `pad_oe` bits are 1.
- R4: When GPIO owns a nibble, `pad_out` carries the data latch bits and `pad_oe` carries the direction bits.
- R5: After reset the data, direction and slew registers all hold 0x00, so every GPIO-owned pin is an input with `pad_oe` low.
- R6: The register addresses are 0 for data, 1 for direction, 2 for slew, and 3 is unused.
  - A write takes effect on the clock edge that samples `bus_sel` and `bus_wr` high.
  - `bus_rdata` shows the old value until that edge.
  - Addresses 1 and 2 read back their register, and address 3 reads 0x00 and ignores writes.
  - The data latch accepts writes whoever owns the pins.
- R7: On a data read, a bit whose direction is 1 returns the stored latch bit.
- R8: On a data read, a bit whose direction is 0 and whose slew bit is 1 returns 1.
- R9: On a data read, a bit whose direction is 0 and whose slew bit is 0 returns the pin level through a two-flop synchronizer. A change at `pad_in` shows on that bit and on `pin_level` after two rising edges.
- R10: A bus cycle with `bus_sel` or `bus_wr` low leaves all three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| stall_en | input | 2 | Stall-detect enable per nibble (bit 1 = upper) |
| stall_out | input | 8 | Stall-detect pin drive values |
| stall_oe | input | 8 | Stall-detect pin output enables |
| pwm_en | input | 2 | PWM pair enable per nibble (bit 1 = upper) |
| pwm_p | input | 4 | PWM channel plus outputs, channel index 3..0 |
| pwm_m | input | 4 | PWM channel minus outputs, channel index 3..0 |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Pin drive values to the pads |
| pad_oe | output | 8 | Pin output enables to the pads |
| pin_level | output | 8 | Synchronized pin levels for peripherals |

## Verification
On every cycle, the checker compares each nibble's pad signals with the owner that the enables select. It also checks the three read classes of the data register against the stored registers and the synchronized pins, checks that registers capture and hold across bus cycles, and checks the two-edge synchronizer delay. Some behaviours can only be shown by the bench's sweeps. These are the reset state at the ports, the absence of any effect from writes to the unused address, and the exact cycle when a new pin level first appears on a read. The bench also sweeps all 16 enable combinations across several peripheral patterns, and 256 combinations of direction, slew, latch and pin values.

// File: rtl/pv_pkg.sv
package pv_pkg;

    typedef enum logic [1:0] {
        OWN_GPIO  = 2'd0,
        OWN_PWM   = 2'd1,
        OWN_STALL = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_SLEW = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pv_sync.sv
module pv_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pv_regs.sv
module pv_regs
    import pv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] sync_in,
    output logic [W-1:0] bus_rdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] slew_q
);

    reg_addr_e    sel_reg;
    logic         wr_data;
    logic         wr_dir;
    logic         wr_slew;
    logic [W-1:0] port_view;

    assign sel_reg = reg_addr_e'(bus_addr);

    // write decode
    always_comb begin
        wr_data = 1'b0;
        wr_dir  = 1'b0;
        wr_slew = 1'b0;
        if (bus_sel && bus_wr) begin
            unique case (sel_reg)
                REG_DATA: wr_data = 1'b1;
                REG_DIR:  wr_dir  = 1'b1;
                REG_SLEW: wr_slew = 1'b1;
                REG_NONE: ;
            endcase
        end
    end

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            slew_q <= '0;
        end else begin
            if (wr_data) data_q <= bus_wdata;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_slew) slew_q <= bus_wdata;
        end
    end

    // per-pin view of the data register
    for (genvar i = 0; i < W; i++) begin : g_view
        always_comb begin
            if (dir_q[i]) begin
                port_view[i] = data_q[i];
            end else if (slew_q[i]) begin
                port_view[i] = 1'b1;
            end else begin
                port_view[i] = sync_in[i];
            end
        end
    end

    // read mux
    always_comb begin
        unique case (sel_reg)
            REG_DATA: bus_rdata = port_view;
            REG_DIR:  bus_rdata = dir_q;
            REG_SLEW: bus_rdata = slew_q;
            REG_NONE: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pv_nibble_mux.sv
module pv_nibble_mux
    import pv_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 stall_en,
    input  logic                 pwm_en,
    input  logic [NIB_W-1:0]     stall_out,
    input  logic [NIB_W-1:0]     stall_oe,
    input  logic [NIB_W/2-1:0]   pwm_p,
    input  logic [NIB_W/2-1:0]   pwm_m,
    input  logic [NIB_W-1:0]     gpio_out,
    input  logic [NIB_W-1:0]     gpio_oe,
    output owner_e               owner,
    output logic [NIB_W-1:0]     pad_out,
    output logic [NIB_W-1:0]     pad_oe
);

    localparam int CH = NIB_W / 2;

    logic [NIB_W-1:0] pwm_word;

    // channel c drives pins 2c+1 (plus) and 2c (minus)
    for (genvar c = 0; c < CH; c++) begin : g_pair
        assign pwm_word[2*c+1] = pwm_p[c];
        assign pwm_word[2*c]   = pwm_m[c];
    end

    // owner selection: stall-detect, then PWM, then GPIO
    always_comb begin
        if (stall_en) begin
            owner = OWN_STALL;
        end else if (pwm_en) begin
            owner = OWN_PWM;
        end else begin
            owner = OWN_GPIO;
        end
    end

    // pad drive per owner
    always_comb begin
        unique case (owner)
            OWN_STALL: begin
                pad_out = stall_out;
                pad_oe  = stall_oe;
            end
            OWN_PWM: begin
                pad_out = pwm_word;
                pad_oe  = '1;
            end
            default: begin
                pad_out = gpio_out;
                pad_oe  = gpio_oe;
            end
        endcase
    end

endmodule

// File: rtl/pv_port_mux.sv
module pv_port_mux
    import pv_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int NUM_NIB     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [1:0]                     bus_addr,
    input  logic [NIB_W*NUM_NIB-1:0]       bus_wdata,
    output logic [NIB_W*NUM_NIB-1:0]       bus_rdata,
    input  logic [NUM_NIB-1:0]             stall_en,
    input  logic [NIB_W*NUM_NIB-1:0]       stall_out,
    input  logic [NIB_W*NUM_NIB-1:0]       stall_oe,
    input  logic [NUM_NIB-1:0]             pwm_en,
    input  logic [NIB_W/2*NUM_NIB-1:0]     pwm_p,
    input  logic [NIB_W/2*NUM_NIB-1:0]     pwm_m,
    input  logic [NIB_W*NUM_NIB-1:0]       pad_in,
    output logic [NIB_W*NUM_NIB-1:0]       pad_out,
    output logic [NIB_W*NUM_NIB-1:0]       pad_oe,
    output logic [NIB_W*NUM_NIB-1:0]       pin_level
);

    localparam int W  = NIB_W * NUM_NIB;
    localparam int CH = NIB_W / 2;

    logic [W-1:0]             data_q;
    logic [W-1:0]             dir_q;
    logic [W-1:0]             slew_q;
    owner_e [NUM_NIB-1:0]     nib_owner;

    pv_sync #(
        .W      (W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_level)
    );

    pv_regs #(
        .W (W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sync_in   (pin_level),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .slew_q    (slew_q)
    );

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
        pv_nibble_mux #(
            .NIB_W (NIB_W)
        ) u_mux (
            .stall_en  (stall_en[n]),
            .pwm_en    (pwm_en[n]),
            .stall_out (stall_out[n*NIB_W +: NIB_W]),
            .stall_oe  (stall_oe[n*NIB_W +: NIB_W]),
            .pwm_p     (pwm_p[n*CH +: CH]),
            .pwm_m     (pwm_m[n*CH +: CH]),
            .gpio_out  (data_q[n*NIB_W +: NIB_W]),
            .gpio_oe   (dir_q[n*NIB_W +: NIB_W]),
            .owner     (nib_owner[n]),
            .pad_out   (pad_out[n*NIB_W +: NIB_W]),
            .pad_oe    (pad_oe[n*NIB_W +: NIB_W])
        );
    end

endmodule

// File: rtl/pv_port_chk.sv
module pv_port_chk
    import pv_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [1:0]                 bus_addr,
    input logic [NIB_W*NUM_NIB-1:0]   bus_wdata,
    input logic [NIB_W*NUM_NIB-1:0]   bus_rdata,
    input logic [NUM_NIB-1:0]         stall_en,
    input logic [NIB_W*NUM_NIB-1:0]   stall_out,
    input logic [NIB_W*NUM_NIB-1:0]   stall_oe,
    input logic [NUM_NIB-1:0]         pwm_en,
    input logic [NIB_W/2*NUM_NIB-1:0] pwm_p,
    input logic [NIB_W/2*NUM_NIB-1:0] pwm_m,
    input logic [NIB_W*NUM_NIB-1:0]   pad_in,
    input logic [NIB_W*NUM_NIB-1:0]   pad_out,
    input logic [NIB_W*NUM_NIB-1:0]   pad_oe,
    input logic [NIB_W*NUM_NIB-1:0]   pin_level,
    input logic [NIB_W*NUM_NIB-1:0]   data_q,
    input logic [NIB_W*NUM_NIB-1:0]   dir_q,
    input logic [NIB_W*NUM_NIB-1:0]   slew_q,
    input owner_e [NUM_NIB-1:0]       nib_owner
);

    localparam int CH = NIB_W / 2;

    logic [1:0] since_rst;
    logic [NIB_W*NUM_NIB-1:0] pwm_pins;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_pins
        for (genvar c = 0; c < CH; c++) begin : g_ch
            assign pwm_pins[n*NIB_W + 2*c + 1] = pwm_p[n*CH + c];
            assign pwm_pins[n*NIB_W + 2*c]     = pwm_m[n*CH + c];
        end
    end

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_own
        AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            stall_en[n] |-> nib_owner[n] == OWN_STALL); // R1
        AST_STALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            stall_en[n] |-> (pad_out[n*NIB_W +: NIB_W] == stall_out[n*NIB_W +: NIB_W]
                          && pad_oe[n*NIB_W +: NIB_W] == stall_oe[n*NIB_W +: NIB_W])); // R2
        AST_PWM_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall_en[n] && pwm_en[n]) |-> (pad_out[n*NIB_W +: NIB_W] == pwm_pins[n*NIB_W +: NIB_W]
                          && pad_oe[n*NIB_W +: NIB_W] == {NIB_W{1'b1}})); // R3
        AST_GPIO_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (!stall_en[n] && !pwm_en[n]) |-> (pad_out[n*NIB_W +: NIB_W] == data_q[n*NIB_W +: NIB_W]
                          && pad_oe[n*NIB_W +: NIB_W] == dir_q[n*NIB_W +: NIB_W])); // R4
    end

    AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> dir_q == $past(bus_wdata)); // R6
    AST_UNUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> bus_rdata == '0); // R6
    AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata & dir_q) == (data_q & dir_q)); // R7
    AST_READ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata & ~dir_q & slew_q) == (~dir_q & slew_q)); // R8
    AST_READ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata & ~dir_q & ~slew_q) == (pin_level & ~dir_q & ~slew_q)); // R9
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> pin_level == $past(pad_in, 2)); // R9
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(data_q) && $stable(dir_q) && $stable(slew_q))); // R10

endmodule

bind pv_port_mux pv_port_chk #(
    .NIB_W   (NIB_W),
    .NUM_NIB (NUM_NIB)
) u_port_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stall_en  (stall_en),
    .stall_out (stall_out),
    .stall_oe  (stall_oe),
    .pwm_en    (pwm_en),
    .pwm_p     (pwm_p),
    .pwm_m     (pwm_m),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pin_level (pin_level),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .slew_q    (slew_q),
    .nib_owner (nib_owner)
);

// File: tb/test_pv_port_mux.sv
`timescale 1ns/1ps
module test_pv_port_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] stall_en = 2'b00;
    logic [7:0] stall_out = 8'h00;
    logic [7:0] stall_oe = 8'h00;
    logic [1:0] pwm_en = 2'b00;
    logic [3:0] pwm_p = 4'h0;
    logic [3:0] pwm_m = 4'h0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pin_level;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    logic [7:0] m_data = 8'h00;
    logic [7:0] m_dir  = 8'h00;
    logic [7:0] m_slew = 8'h00;

    always #2.5 clk = ~clk;

    pv_port_mux i_pv_port_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stall_en  (stall_en),
        .stall_out (stall_out),
        .stall_oe  (stall_oe),
        .pwm_en    (pwm_en),
        .pwm_p     (pwm_p),
        .pwm_m     (pwm_m),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pin_level (pin_level)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            2'd0: m_data = v;
            2'd1: m_dir  = v;
            2'd2: m_slew = v;
            default: ;
        endcase
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // expected nibble drive, computed from the ownership rules
    function automatic logic [3:0] exp_nib(input int n, input bit want_oe);
        logic [3:0] r;
        if (stall_en[n]) begin
            r = want_oe ? stall_oe[n*4 +: 4] : stall_out[n*4 +: 4];
        end else if (pwm_en[n]) begin
            r = want_oe ? 4'hF : {pwm_p[2*n+1], pwm_m[2*n+1], pwm_p[2*n], pwm_m[2*n]};
        end else begin
            r = want_oe ? m_dir[n*4 +: 4] : m_data[n*4 +: 4];
        end
        return r;
    endfunction

    function automatic string nib_req(input int n);
        if (stall_en[n] && pwm_en[n]) return "R1";
        if (stall_en[n]) return "R2";
        if (pwm_en[n]) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state
        check("R5 pad_oe", pad_oe, 8'h00);
        check("R5 pad_out", pad_out, 8'h00);
        read_reg(2'd0, rd); check("R5 data read", rd, 8'h00);
        read_reg(2'd1, rd); check("R5 dir", rd, 8'h00);
        read_reg(2'd2, rd); check("R5 slew", rd, 8'h00);

        // R6: write timing, old value until the capturing edge
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h5A;
        #1; check("R6 before edge", bus_rdata, 8'h00);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; m_dir = 8'h5A;
        #1; check("R6 after edge", bus_rdata, 8'h5A);

        // ownership sweep, all enable combinations, several patterns
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'hA5);
        for (int pat = 0; pat < 4; pat++) begin
            for (int combo = 0; combo < 16; combo++) begin
                @(negedge clk);
                stall_en  = combo[1:0];
                pwm_en    = combo[3:2];
                stall_out = 8'h96 ^ 8'(pat * 37 + combo);
                stall_oe  = 8'h5A ^ 8'(pat * 91 + combo * 3);
                pwm_p     = 4'(pat * 5 + combo);
                pwm_m     = 4'(pat * 3 + combo * 7);
                #1;
                for (int n = 0; n < 2; n++) begin
                    check(nib_req(n), {4'h0, pad_out[n*4 +: 4]}, {4'h0, exp_nib(n, 1'b0)});
                    check(nib_req(n), {4'h0, pad_oe[n*4 +: 4]},  {4'h0, exp_nib(n, 1'b1)});
                end
            end
        end

        // R6: data latch writable while a peripheral owns the pins
        @(negedge clk);
        stall_en = 2'b11; pwm_en = 2'b00;
        bus_write(2'd0, 8'h81);
        #1; check("R2 stall during write", pad_out, stall_out);
        stall_en = 2'b00;
        bus_write(2'd1, 8'hFF);
        #1; check("R6 latch under ownership", pad_out, 8'h81);
        check("R4 all outputs", pad_oe, 8'hFF);

        // R9: synchronizer latency
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hC3; bus_addr = 2'd0;
        #1; check("R9 no change yet", bus_rdata, 8'h00);
        @(negedge clk); #1; check("R9 one edge", bus_rdata, 8'h00);
        @(negedge clk); #1; check("R9 two edges", bus_rdata, 8'hC3);
        check("R9 pin_level", pin_level, 8'hC3);

        // read-path sweep: R7, R8, R9 and readback R6
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vv;
            logic [7:0] in_only;
            vv = 8'(v);
            bus_write(2'd1, vv);
            bus_write(2'd2, {vv[3:0], vv[7:4]} ^ 8'h33);
            bus_write(2'd0, ~vv);
            pad_in = vv ^ 8'h6C;
            repeat (2) @(negedge clk);
            read_reg(2'd0, rd);
            in_only = ~m_dir & ~m_slew;
            check("R7", rd & m_dir, m_data & m_dir);
            check("R8", rd & ~m_dir & m_slew, ~m_dir & m_slew);
            check("R9", rd & in_only, pad_in & in_only);
            read_reg(2'd1, rd); check("R6 dir readback", rd, m_dir);
            read_reg(2'd2, rd); check("R6 slew readback", rd, m_slew);
        end

        // R10: bus cycles without both strobes change nothing
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = ~m_dir;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = ~m_slew;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        read_reg(2'd1, rd); check("R10 dir kept", rd, m_dir);
        read_reg(2'd2, rd); check("R10 slew kept", rd, m_slew);
        check("R10 pad_out kept", pad_out, m_data);

        // R6: unused address reads zero and ignores writes
        bus_write(2'd3, 8'hFF);
        read_reg(2'd3, rd); check("R6 unused reads 0", rd, 8'h00);
        read_reg(2'd1, rd); check("R6 dir after unused write", rd, m_dir);
        read_reg(2'd2, rd); check("R6 slew after unused write", rd, m_slew);
        check("R6 data after unused write", pad_out, m_data);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule